// File: doc/BRIEF.md
# Six-Bit General-Purpose I/O Port

This block is the parallel I/O port of a small microcontroller core. It holds a six-bit output data latch and a six-bit direction register. Each direction bit chooses whether the pad is driven from the latch or left at high impedance. The CPU writes the latch and loads the direction register through separate strobes with 8-bit data. It reads the port on an 8-bit bus that always shows the live pad levels, whatever direction each pin has.

Pin 3 is input-only and can serve as the reset pin. In that role its weak pull-up is forced on and it takes no part in wake-on-change. A fixed group of pins (0, 1 and 3) shares one weak pull-up enable and one wake-on-change enable. Pins given to an alternate function read as zero and the port stops driving them. The driver of pin 2 can be turned off by an option control. Wake-on-change compares the group pins against the levels captured at the most recent port read and raises a registered wake request when they differ.

A read-modify-write bit operation is built by the CPU from a port read followed by a latch write. The read shows pad levels, so the latch bit of an input pin takes on the level seen at that pin.

Top module: `gpio6_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every pad output enable is 0, every pad output value is 0 and the wake request is 0.
- R2: Raising the direction strobe loads bits 5:0 of the direction data at the next clock edge, and bits 7:6 are ignored. A direction bit of 0 enables that pad's driver and a bit of 1 releases it. Pins 3 and 2 are the exceptions covered by R3 and R7.
- R3: The pad output enable of pin 3 is always 0, whatever its direction bit and latch value.
- R4: Raising the latch strobe stores bits 5:0 of the latch data at the next clock edge, and bits 7:6 are ignored. The pad output values show the latch and hold until the next latch write. A latch write and a direction load in the same cycle both take effect.
- R5: The read bus bits 5:0 show the present pad input levels, whatever the direction bits are. Bits 7:6 always read 0.
- R6: A pin whose alternate-function bit is 1 reads as 0 and has its driver released. Pin 3 also reads as 0 while reset-pin mode is on.
- R7: While the pin 2 override input is 1, the pad output enable of pin 2 is 0, whatever its direction bit.
- R8: The pull-up enable input turns on the weak pull-ups of pins 0, 1 and 3 together. Reset-pin mode forces the pull-up of pin 3 on. Pins 2, 4 and 5 never get a pull-up.
- R9: With wake-on-change enabled, the wake request is 1 in the cycle after a clock edge at which any of pins 0, 1, 3 differs from the reference captured at the last port-read strobe. Pin 3 is left out while reset-pin mode is on. With wake-on-change disabled, the wake request is 0 after the next edge.
- R10: When a port-read strobe and a pin change fall on the same edge, the comparison at that edge uses the previous reference. The wake request then rises for exactly one cycle, because the reference has taken the new level.
- R11: If a port read is followed by a latch write of that value with one bit set, the latch bit of an input pin holds that pin's level. The level appears on the pad once the pin is turned to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_we_i | input | 1 | Output latch write strobe |
| lat_wdata_i | input | 8 | Output latch write data |
| dir_we_i | input | 1 | Direction register load strobe |
| dir_wdata_i | input | 8 | Direction register load data (1 = high impedance) |
| rd_i | input | 1 | Port read strobe; captures the wake reference |
| rd_data_o | output | 8 | Port read data (live pad levels) |
| altfn_i | input | 6 | Per-pin alternate-function select |
| rst_pin_en_i | input | 1 | Pin 3 serves as the reset input |
| pu_en_i | input | 1 | Group weak pull-up enable |
| woc_en_i | input | 1 | Group wake-on-change enable |
| gp2_ovr_i | input | 1 | Pin 2 driver override |
| pad_oe_o | output | 6 | Pad output enables |
| pad_out_o | output | 6 | Pad output values |
| pad_in_i | input | 6 | Pad input levels |
| pad_pu_o | output | 6 | Pad weak pull-up enables |
| wake_o | output | 1 | Wake request |

## Verification
Two things can happen on one edge: a port-read strobe that moves the wake reference, and a pin change that the wake comparator must judge. The bench raises the read strobe at the same edge where a group pin toggles. It expects the wake request high for exactly the next cycle and low after the following edge. This shows that the comparison used the old reference and the capture took the new level. A latch write and a direction load in one cycle are also issued together, and both results are checked on the pads.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
    // default port geometry
    localparam int NPIN_DEF   = 6;
    localparam int BUS_W_DEF  = 8;
    localparam int INONLY_DEF = 3;   // input-only pin, doubles as reset
    localparam int OVR_DEF    = 2;   // pin whose driver has an option override
    // pins sharing the group pull-up and wake-on-change control
    localparam logic [NPIN_DEF-1:0] GRP_MASK_DEF = 6'b001011;
endpackage

// File: rtl/gpio6_regfile.sv
module gpio6_regfile #(
    parameter int NPIN  = gpio6_pkg::NPIN_DEF,
    parameter int BUS_W = gpio6_pkg::BUS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lat_we,
    input  logic [BUS_W-1:0] lat_wdata,
    input  logic             dir_we,
    input  logic [BUS_W-1:0] dir_wdata,
    output logic [NPIN-1:0]  lat_q,
    output logic [NPIN-1:0]  dir_q
);
    typedef struct packed {
        logic [NPIN-1:0] lat;
        logic [NPIN-1:0] dir;
    } regs_t;

    regs_t st_d, st_q;

    // upper bus bits have no storage behind them
    logic unused_hi;
    assign unused_hi = ^{lat_wdata[BUS_W-1:NPIN], dir_wdata[BUS_W-1:NPIN]};

    always_comb begin
        st_d = st_q;
        if (lat_we) st_d.lat = lat_wdata[NPIN-1:0];
        if (dir_we) st_d.dir = dir_wdata[NPIN-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat <= '0;
            st_q.dir <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_q = st_q.lat;
    assign dir_q = st_q.dir;
endmodule

// File: rtl/gpio6_padctl.sv
module gpio6_padctl #(
    parameter int              NPIN       = gpio6_pkg::NPIN_DEF,
    parameter int              INONLY_IDX = gpio6_pkg::INONLY_DEF,
    parameter int              OVR_IDX    = gpio6_pkg::OVR_DEF,
    parameter logic [NPIN-1:0] GRP_MASK   = gpio6_pkg::GRP_MASK_DEF
) (
    input  logic [NPIN-1:0] lat_q,
    input  logic [NPIN-1:0] dir_q,
    input  logic [NPIN-1:0] alt_eff,
    input  logic            ovr,
    input  logic            pu_en,
    input  logic            rst_pin_en,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_pu
);
    assign pad_out = lat_q;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        // driver enable per pin variant
        if (i == INONLY_IDX) begin : g_inonly
            logic unused_pin;
            assign unused_pin = dir_q[i] ^ alt_eff[i];
            assign pad_oe[i]  = 1'b0;
        end else if (i == OVR_IDX) begin : g_ovr
            assign pad_oe[i] = ~dir_q[i] & ~alt_eff[i] & ~ovr;
        end else begin : g_plain
            assign pad_oe[i] = ~dir_q[i] & ~alt_eff[i];
        end

        // weak pull-up per pin variant
        if (GRP_MASK[i] && i == INONLY_IDX) begin : g_pu_rst
            assign pad_pu[i] = pu_en | rst_pin_en;
        end else if (GRP_MASK[i]) begin : g_pu_grp
            assign pad_pu[i] = pu_en;
        end else begin : g_pu_none
            assign pad_pu[i] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio6_woc.sv
module gpio6_woc #(
    parameter int              NPIN       = gpio6_pkg::NPIN_DEF,
    parameter int              INONLY_IDX = gpio6_pkg::INONLY_DEF,
    parameter logic [NPIN-1:0] GRP_MASK   = gpio6_pkg::GRP_MASK_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd,
    input  logic [NPIN-1:0] pad_in,
    input  logic            woc_en,
    input  logic            rst_pin_en,
    output logic            wake
);
    typedef struct packed {
        logic [NPIN-1:0] snap;
        logic            wake;
    } woc_t;

    woc_t st_d, st_q;
    logic [NPIN-1:0] watch;

    for (genvar i = 0; i < NPIN; i++) begin : g_watch
        if (i == INONLY_IDX) begin : g_rst
            assign watch[i] = GRP_MASK[i] & ~rst_pin_en;
        end else begin : g_grp
            assign watch[i] = GRP_MASK[i];
        end
    end

    always_comb begin
        st_d = st_q;
        // compare against the reference held before this edge
        st_d.wake = woc_en & (|((pad_in ^ st_q.snap) & watch));
        if (rd) st_d.snap = pad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake = st_q.wake;
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port #(
    parameter int              NPIN       = gpio6_pkg::NPIN_DEF,
    parameter int              BUS_W      = gpio6_pkg::BUS_W_DEF,
    parameter int              INONLY_IDX = gpio6_pkg::INONLY_DEF,
    parameter int              OVR_IDX    = gpio6_pkg::OVR_DEF,
    parameter logic [NPIN-1:0] GRP_MASK   = gpio6_pkg::GRP_MASK_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lat_we_i,
    input  logic [BUS_W-1:0] lat_wdata_i,
    input  logic             dir_we_i,
    input  logic [BUS_W-1:0] dir_wdata_i,
    input  logic             rd_i,
    output logic [BUS_W-1:0] rd_data_o,
    input  logic [NPIN-1:0]  altfn_i,
    input  logic             rst_pin_en_i,
    input  logic             pu_en_i,
    input  logic             woc_en_i,
    input  logic             gp2_ovr_i,
    output logic [NPIN-1:0]  pad_oe_o,
    output logic [NPIN-1:0]  pad_out_o,
    input  logic [NPIN-1:0]  pad_in_i,
    output logic [NPIN-1:0]  pad_pu_o,
    output logic             wake_o
);
    localparam logic [NPIN-1:0] RST_BIT = NPIN'(1) << INONLY_IDX;

    logic [NPIN-1:0] lat_q, dir_q, alt_eff;

    // reset-pin mode counts as an alternate function of the input-only pin
    assign alt_eff = altfn_i | (rst_pin_en_i ? RST_BIT : '0);

    gpio6_regfile #(.NPIN(NPIN), .BUS_W(BUS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_we    (lat_we_i),
        .lat_wdata (lat_wdata_i),
        .dir_we    (dir_we_i),
        .dir_wdata (dir_wdata_i),
        .lat_q     (lat_q),
        .dir_q     (dir_q)
    );

    gpio6_padctl #(
        .NPIN(NPIN), .INONLY_IDX(INONLY_IDX), .OVR_IDX(OVR_IDX), .GRP_MASK(GRP_MASK)
    ) u_pad (
        .lat_q      (lat_q),
        .dir_q      (dir_q),
        .alt_eff    (alt_eff),
        .ovr        (gp2_ovr_i),
        .pu_en      (pu_en_i),
        .rst_pin_en (rst_pin_en_i),
        .pad_oe     (pad_oe_o),
        .pad_out    (pad_out_o),
        .pad_pu     (pad_pu_o)
    );

    gpio6_woc #(
        .NPIN(NPIN), .INONLY_IDX(INONLY_IDX), .GRP_MASK(GRP_MASK)
    ) u_woc (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (rd_i),
        .pad_in     (pad_in_i),
        .woc_en     (woc_en_i),
        .rst_pin_en (rst_pin_en_i),
        .wake       (wake_o)
    );

    // live, unlatched read path
    for (genvar b = 0; b < BUS_W; b++) begin : g_rd
        if (b < NPIN) begin : g_pin
            assign rd_data_o[b] = pad_in_i[b] & ~alt_eff[b];
        end else begin : g_pad
            assign rd_data_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk #(
    parameter int NPIN  = 6,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lat_we_i,
    input logic [BUS_W-1:0] lat_wdata_i,
    input logic [BUS_W-1:0] rd_data_o,
    input logic             rst_pin_en_i,
    input logic             woc_en_i,
    input logic             gp2_ovr_i,
    input logic [NPIN-1:0]  pad_oe_o,
    input logic [NPIN-1:0]  pad_out_o,
    input logic [NPIN-1:0]  pad_pu_o,
    input logic             wake_o
);
    a_r1_release_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe_o == '0 && pad_out_o == '0 && !wake_o));

    a_r3_inonly_never_driven: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe_o[3] == 1'b0);

    a_r4_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        lat_we_i |=> pad_out_o == $past(lat_wdata_i[NPIN-1:0]));

    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_we_i |=> $stable(pad_out_o));

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[BUS_W-1:NPIN] == '0);

    a_r7_gp2_override: assert property (@(posedge clk) disable iff (!rst_n)
        gp2_ovr_i |-> !pad_oe_o[2]);

    a_r8_rstpin_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin_en_i |-> pad_pu_o[3]);

    a_r8_no_pullup_outside: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pu_o[5:4] == 2'b00 && !pad_pu_o[2]);

    a_r9_wake_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !woc_en_i |=> !wake_o);
endmodule

bind gpio6_port gpio6_port_chk #(.NPIN(NPIN), .BUS_W(BUS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lat_we_i     (lat_we_i),
    .lat_wdata_i  (lat_wdata_i),
    .rd_data_o    (rd_data_o),
    .rst_pin_en_i (rst_pin_en_i),
    .woc_en_i     (woc_en_i),
    .gp2_ovr_i    (gp2_ovr_i),
    .pad_oe_o     (pad_oe_o),
    .pad_out_o    (pad_out_o),
    .pad_pu_o     (pad_pu_o),
    .wake_o       (wake_o)
);

// File: tb/gpio6_port_bench.sv
module gpio6_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lat_we = 1'b0, dir_we = 1'b0, rd = 1'b0;
    logic [7:0] lat_wdata = '0, dir_wdata = '0;
    logic [7:0] rd_data;
    logic [5:0] altfn = '0;
    logic       rst_pin_en = 1'b0, pu_en = 1'b0, woc_en = 1'b0, gp2_ovr = 1'b0;
    logic [5:0] pad_oe, pad_out, pad_pu;
    logic [5:0] pad_in = '0;
    logic       wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio6_port u_gpio6_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .lat_we_i     (lat_we),
        .lat_wdata_i  (lat_wdata),
        .dir_we_i     (dir_we),
        .dir_wdata_i  (dir_wdata),
        .rd_i         (rd),
        .rd_data_o    (rd_data),
        .altfn_i      (altfn),
        .rst_pin_en_i (rst_pin_en),
        .pu_en_i      (pu_en),
        .woc_en_i     (woc_en),
        .gp2_ovr_i    (gp2_ovr),
        .pad_oe_o     (pad_oe),
        .pad_out_o    (pad_out),
        .pad_in_i     (pad_in),
        .pad_pu_o     (pad_pu),
        .wake_o       (wake)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock edge, then return at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_dir(input logic [7:0] v);
        dir_wdata = v; dir_we = 1'b1;
        tick();
        dir_we = 1'b0;
    endtask

    task automatic load_lat(input logic [7:0] v);
        lat_wdata = v; lat_we = 1'b1;
        tick();
        lat_we = 1'b0;
    endtask

    task automatic port_read();
        rd = 1'b1;
        tick();
        rd = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] exp_oe;
        @(negedge clk);
        // R1: reset state, then first cycle after release
        check("R1 oe in reset", {2'b0, pad_oe}, 8'h00);
        check("R1 out in reset", {2'b0, pad_out}, 8'h00);
        check("R1 wake in reset", {7'b0, wake}, 8'h00);
        tick();
        rst_n = 1'b1;
        tick();
        check("R1 oe after reset", {2'b0, pad_oe}, 8'h00);
        check("R1 out after reset", {2'b0, pad_out}, 8'h00);

        // R4: latch write, upper bits ignored, hold
        load_lat(8'hEA);
        check("R4 latch write", {2'b0, pad_out}, 8'h2A);
        tick(); tick();
        check("R4 latch hold", {2'b0, pad_out}, 8'h2A);

        // R2 R3 R7: direction sweep with and without pin 2 override
        for (int ov = 0; ov < 2; ov++) begin
            gp2_ovr = ov[0];
            for (int d = 0; d < 64; d++) begin
                load_dir(8'(d) | 8'hC0);
                exp_oe = ~6'(d) & 6'b110111 & (ov[0] ? 6'b111011 : 6'b111111);
                check("R2/R3/R7 oe sweep", {2'b0, pad_oe}, {2'b0, exp_oe});
            end
        end
        gp2_ovr = 1'b0;
        check("R3 pin3 never driven", {7'b0, pad_oe[3]}, 8'h00);

        // R4/R2: simultaneous latch write and direction load
        lat_wdata = 8'h15; lat_we = 1'b1;
        dir_wdata = 8'h00; dir_we = 1'b1;
        tick();
        lat_we = 1'b0; dir_we = 1'b0;
        check("R4 same-cycle latch", {2'b0, pad_out}, 8'h15);
        check("R2 same-cycle dir", {2'b0, pad_oe}, 8'h37);

        // R6: alternate function releases driver
        altfn = 6'h05;
        #1;
        check("R6 alt releases oe", {2'b0, pad_oe}, 8'h32);

        // R5 R6: read sweep across pad levels, alt masks and reset-pin mode
        for (int r = 0; r < 2; r++) begin
            for (int a = 0; a < 3; a++) begin
                for (int p = 0; p < 64; p++) begin
                    logic [5:0] am;
                    am = (a == 0) ? 6'h00 : (a == 1) ? 6'h15 : 6'h2A;
                    altfn = am; rst_pin_en = r[0]; pad_in = 6'(p);
                    #1;
                    check("R5/R6 read sweep", rd_data,
                          {2'b00, 6'(p) & ~am & (r[0] ? 6'b110111 : 6'b111111)});
                end
            end
        end
        altfn = '0; rst_pin_en = 1'b0; pad_in = '0;

        // R8: pull-up combinations
        for (int c = 0; c < 4; c++) begin
            pu_en = c[0]; rst_pin_en = c[1];
            #1;
            check("R8 pullups", {2'b0, pad_pu},
                  {2'b0, (c[0] ? 6'b001011 : 6'b000000) | (c[1] ? 6'b001000 : 6'b000000)});
        end
        pu_en = 1'b0; rst_pin_en = 1'b0;

        // R9: single-pin toggle per pin, reset-pin mode off and on
        woc_en = 1'b1;
        for (int r = 0; r < 2; r++) begin
            rst_pin_en = r[0];
            for (int k = 0; k < 6; k++) begin
                pad_in = '0;
                port_read();
                tick();
                check("R9 quiet", {7'b0, wake}, 8'h00);
                pad_in = 6'(1) << k;
                tick();
                check("R9 toggle wake", {7'b0, wake},
                      {7'b0, (k == 0 || k == 1 || (k == 3 && !r[0]))});
            end
        end
        rst_pin_en = 1'b0;
        // R9: disabled wake-on-change
        pad_in = 6'h01;
        tick();
        check("R9 enabled mismatch", {7'b0, wake}, 8'h01);
        woc_en = 1'b0;
        tick();
        check("R9 disabled", {7'b0, wake}, 8'h00);

        // R10: read strobe and pin change on the same edge
        woc_en = 1'b1;
        pad_in = 6'h00;
        port_read();
        tick();
        pad_in = 6'h02; rd = 1'b1;
        tick();
        rd = 1'b0;
        check("R10 pulse high", {7'b0, wake}, 8'h01);
        tick();
        check("R10 pulse cleared", {7'b0, wake}, 8'h00);
        woc_en = 1'b0;

        // R11: read-modify-write copies input pin level into latch
        load_lat(8'h00);
        load_dir(8'h1F);        // pin 5 output, pin 0 input
        pad_in = 6'h01;
        #1;
        lat_wdata = rd_data | 8'h20; lat_we = 1'b1;
        tick();
        lat_we = 1'b0;
        pad_in = 6'h00;
        load_dir(8'h1E);        // pin 0 now output
        check("R11 rmw latch bit0", {7'b0, pad_out[0]}, 8'h01);
        check("R11 rmw latch bit5", {7'b0, pad_out[5]}, 8'h01);
        check("R11 pin0 driven", {7'b0, pad_oe[0]}, 8'h01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule